// File: doc/BRIEF.md
# Direct-Mapped Address Translation Unit

This block turns a 32-bit virtual address into a physical address for a processor core. It keeps two separate direct-mapped tables, one for instruction fetches and one for data accesses. Each table has 64 entries by default, and each entry describes one 8 KB page. An entry pairs a tag-and-valid word with a frame-and-permission word. The permission word holds separate read, write and execute grants for supervisor mode and for user mode.

The core presents a request with an address, an access kind and its current privilege level. One cycle later the block answers with either a translated address plus the granted rights, or a fault code. A fault is classed as a table miss or as a page fault, and each class is split into an instruction side and a data side. The virtual address of the most recent fault is held in a capture register for the trap handler.

Supervisor accesses below address 0x2000 bypass the tables and map to themselves. A write port lets software place one entry per cycle into either table.

Top module: `tlbx_unit`

## Requirements
- R1: While reset is asserted, and right after it, `rsp_valid` is 0 and `fault_addr` is 0. Every entry in both tables is invalid after reset, so any lookup that is not bypassed reports a miss.
- R2: The page number is `addr[31:13]`. The table index is `addr[18:13]`. Entry words are laid out as follows: tag-and-valid word = {page number in bits 31:13, valid in bit 0}; frame-and-permission word = {frame in bits 31:13, permissions in bits 5:0}.
- R3: If the stored page number differs from the request's page number, the block reports a miss. The fault code is 1 for a fetch and 2 for a data access.
- R4: An entry whose page number matches but whose valid bit is 0 reports the same miss codes as R3.
- R5: Permission bits: bit 0 supervisor read, bit 1 supervisor write, bit 2 supervisor execute, bit 3 user read, bit 4 user write, bit 5 user execute. The set used follows `req_super`. `rsp_rights` is laid out as bit 0 read, bit 1 write, bit 2 execute. A fetch reports only the execute right. A data access reports only the read and write rights.
- R6: Each access needs one right: a fetch needs execute, a write (kind 1) needs write, and a read (kind 0 or 3) needs read. Without it the block reports a page fault: code 3 for a fetch, code 4 for data. Kind 2 is a fetch.
- R7: On a hit, `rsp_paddr` is the entry frame joined with `addr[12:0]`, which passes through unchanged.
- R8: A supervisor request below 0x2000 is a hit with `rsp_paddr` equal to the address and rights 3'b011. This applies to any access kind. User requests in that range are translated as usual.
- R9: `fault_addr` takes the request address on every faulting response and keeps its value otherwise.
- R10: `rsp_valid` is high exactly one cycle after `req_valid`, and the response fields belong to that request.
- R11: An entry write selects a table with `wr_instr` (1 = instruction), an index and both words. A lookup sees the new entry from the next cycle on; a lookup in the same cycle sees the old contents. A write to one table leaves the other table unchanged.
- R12: A faulting response has `rsp_hit` = 0, `rsp_paddr` = 0 and `rsp_rights` = 0. A hit has fault code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_super | input | 1 | Supervisor-mode flag |
| wr_en | input | 1 | Entry write strobe |
| wr_instr | input | 1 | Table select: 1 instruction, 0 data |
| wr_index | input | 6 | Entry index to write |
| wr_match | input | 32 | Tag-and-valid word |
| wr_xlate | input | 32 | Frame-and-permission word |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 32 | Physical address |
| rsp_rights | output | 3 | Granted rights {execute, write, read} |
| rsp_fault | output | 3 | 0 none, 1 instr miss, 2 data miss, 3 instr page fault, 4 data page fault |
| fault_addr | output | 32 | Address of the latest fault |

## Verification
Some rules can be stated from the ports alone, and the assertions check these on every cycle:
- the one-cycle response timing;
- hit and fault never being reported together;
- the page offset passing through unchanged;
- identity mapping in the bypass window;
- write rights on successful writes;
- fault address capture and hold;
- entry loading.

Other behaviour depends on what earlier writes left in the tables, and only the bench's scenarios can show it:
- which side of the tables is consulted;
- telling a tag mismatch from an invalid entry;
- choosing supervisor or user grants;
- a lookup that overlaps a write to the same entry.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  // access kind as presented on req_kind
  typedef enum logic [1:0] {
    KIND_READ    = 2'd0,
    KIND_WRITE   = 2'd1,
    KIND_FETCH   = 2'd2,
    KIND_READ_B  = 2'd3
  } kind_e;

  // classification of a single lookup
  typedef enum logic [1:0] {
    LK_MATCH   = 2'd0,
    LK_NOMATCH = 2'd1,
    LK_INVALID = 2'd2,
    LK_BADADDR = 2'd3
  } lookup_e;

  // fault code reported to the core
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_IMISS = 3'd1,
    FLT_DMISS = 3'd2,
    FLT_IPAGE = 3'd3,
    FLT_DPAGE = 3'd4
  } fault_e;

  // permission field inside the frame-and-permission word
  localparam int PERM_W = 6;
  localparam int PB_SUP_RD = 0;
  localparam int PB_SUP_WR = 1;
  localparam int PB_SUP_EX = 2;
  localparam int PB_USR_RD = 3;
  localparam int PB_USR_WR = 4;
  localparam int PB_USR_EX = 5;

  // granted rights vector
  localparam int RIGHTS_W = 3;
  localparam int RT_RD = 0;
  localparam int RT_WR = 1;
  localparam int RT_EX = 2;

endpackage

// File: rtl/tlbx_table.sv
module tlbx_table
  import tlbx_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [TAG_W-1:0]  wr_frame,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [TAG_W-1:0]  rd_frame,
  output logic [PERM_W-1:0] rd_perm
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  vld_d;
  logic [TAG_W-1:0]  tag_q   [DEPTH];
  logic [TAG_W-1:0]  frame_q [DEPTH];
  logic [PERM_W-1:0] perm_q  [DEPTH];

  // valid bits: next-state
  always_comb begin
    vld_d = vld_q;
    if (wr_en) begin
      vld_d[wr_idx] = wr_valid;
    end
  end

  // valid bits: register, cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // payload storage, no reset, written under enable
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]   <= wr_tag;
      frame_q[wr_idx] <= wr_frame;
      perm_q[wr_idx]  <= wr_perm;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_frame = frame_q[rd_idx];
  assign rd_perm  = perm_q[rd_idx];

  AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_valid)) &&
              (tag_q[$past(wr_idx)] == $past(wr_tag))) else $error("entry load"); // R11
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q)) else $error("valid bits moved without write"); // R11

endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
  import tlbx_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              PAGE_BITS  = 13,
  parameter logic [ADDR_W-1:0] BYPASS_TOP = 32'h0000_2000
) (
  input  logic [ADDR_W-1:0]           req_addr,
  input  kind_e                       req_kind,
  input  logic                        req_super,
  input  logic                        ent_valid,
  input  logic [ADDR_W-PAGE_BITS-1:0] ent_tag,
  input  logic [ADDR_W-PAGE_BITS-1:0] ent_frame,
  input  logic [PERM_W-1:0]           ent_perm,
  output lookup_e                     res,
  output logic [ADDR_W-1:0]           phys,
  output logic [RIGHTS_W-1:0]         rights
);

  localparam int TAG_W = ADDR_W - PAGE_BITS;

  logic [TAG_W-1:0]     vpn;
  logic [PAGE_BITS-1:0] offset;
  logic                 bypass;
  logic                 tag_eq;
  logic                 is_fetch;
  logic                 is_write;
  logic                 g_rd;
  logic                 g_wr;
  logic                 g_ex;
  logic                 denied;

  assign vpn      = req_addr[ADDR_W-1:PAGE_BITS];
  assign offset   = req_addr[PAGE_BITS-1:0];
  assign bypass   = req_super && (req_addr < BYPASS_TOP);
  assign tag_eq   = (ent_tag == vpn);
  assign is_fetch = (req_kind == KIND_FETCH);
  assign is_write = (req_kind == KIND_WRITE);

  // grants from the privilege-selected permission set
  assign g_rd = req_super ? ent_perm[PB_SUP_RD] : ent_perm[PB_USR_RD];
  assign g_wr = req_super ? ent_perm[PB_SUP_WR] : ent_perm[PB_USR_WR];
  assign g_ex = req_super ? ent_perm[PB_SUP_EX] : ent_perm[PB_USR_EX];

  always_comb begin
    if (is_fetch) begin
      denied = !g_ex;
    end else if (is_write) begin
      denied = !g_wr;
    end else begin
      denied = !g_rd;
    end
  end

  always_comb begin
    res    = LK_MATCH;
    phys   = '0;
    rights = '0;
    if (bypass) begin
      phys          = req_addr;
      rights[RT_RD] = 1'b1;
      rights[RT_WR] = 1'b1;
    end else if (!tag_eq) begin
      res = LK_NOMATCH;
    end else if (!ent_valid) begin
      res = LK_INVALID;
    end else if (denied) begin
      res = LK_BADADDR;
    end else begin
      phys = {ent_frame, offset};
      if (is_fetch) begin
        rights[RT_EX] = g_ex;
      end else begin
        rights[RT_RD] = g_rd;
        rights[RT_WR] = g_wr;
      end
    end
  end

endmodule

// File: rtl/tlbx_unit.sv
module tlbx_unit
  import tlbx_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                PAGE_BITS  = 13,
  parameter int                IDX_W      = 6,
  parameter logic [ADDR_W-1:0] BYPASS_TOP = 32'h0000_2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_kind,
  input  logic                req_super,
  input  logic                wr_en,
  input  logic                wr_instr,
  input  logic [IDX_W-1:0]    wr_index,
  input  logic [ADDR_W-1:0]   wr_match,
  input  logic [ADDR_W-1:0]   wr_xlate,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic [RIGHTS_W-1:0] rsp_rights,
  output logic [2:0]          rsp_fault,
  output logic [ADDR_W-1:0]   fault_addr
);

  localparam int TAG_W  = ADDR_W - PAGE_BITS;
  localparam int SIDES  = 2;
  localparam int SIDE_I = 1;

  kind_e             kind;
  logic              sel_instr;
  logic [IDX_W-1:0]  rd_idx;
  logic              side_valid [SIDES];
  logic [TAG_W-1:0]  side_tag   [SIDES];
  logic [TAG_W-1:0]  side_frame [SIDES];
  logic [PERM_W-1:0] side_perm  [SIDES];

  lookup_e             lk_res;
  logic [ADDR_W-1:0]   lk_phys;
  logic [RIGHTS_W-1:0] lk_rights;
  fault_e              flt_d;

  logic                rsp_valid_q;
  logic                rsp_hit_q;
  logic                rsp_hit_d;
  logic [ADDR_W-1:0]   rsp_paddr_q;
  logic [RIGHTS_W-1:0] rsp_rights_q;
  logic [2:0]          rsp_fault_q;
  logic [ADDR_W-1:0]   fault_addr_q;
  logic [ADDR_W-1:0]   fault_addr_d;
  logic                rsp_en;
  logic                fa_en;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_match[PAGE_BITS-1:1], wr_xlate[PAGE_BITS-1:PERM_W]};

  assign kind      = kind_e'(req_kind);
  assign sel_instr = (kind == KIND_FETCH);
  assign rd_idx    = req_addr[PAGE_BITS +: IDX_W];

  // one table per side: index 0 data, index 1 instruction
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic side_wr;
    assign side_wr = wr_en && (wr_instr == (s == SIDE_I));
    tlbx_table #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
    ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (side_wr),
      .wr_idx   (wr_index),
      .wr_valid (wr_match[0]),
      .wr_tag   (wr_match[ADDR_W-1:PAGE_BITS]),
      .wr_frame (wr_xlate[ADDR_W-1:PAGE_BITS]),
      .wr_perm  (wr_xlate[PERM_W-1:0]),
      .rd_idx   (rd_idx),
      .rd_valid (side_valid[s]),
      .rd_tag   (side_tag[s]),
      .rd_frame (side_frame[s]),
      .rd_perm  (side_perm[s])
    );
  end

  tlbx_lookup #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .BYPASS_TOP (BYPASS_TOP)
  ) u_lookup (
    .req_addr  (req_addr),
    .req_kind  (kind),
    .req_super (req_super),
    .ent_valid (sel_instr ? side_valid[SIDE_I] : side_valid[0]),
    .ent_tag   (sel_instr ? side_tag[SIDE_I]   : side_tag[0]),
    .ent_frame (sel_instr ? side_frame[SIDE_I] : side_frame[0]),
    .ent_perm  (sel_instr ? side_perm[SIDE_I]  : side_perm[0]),
    .res       (lk_res),
    .phys      (lk_phys),
    .rights    (lk_rights)
  );

  // fault classification: next-state
  always_comb begin
    unique case (lk_res)
      LK_MATCH:                flt_d = FLT_NONE;
      LK_NOMATCH, LK_INVALID:  flt_d = sel_instr ? FLT_IMISS : FLT_DMISS;
      default:                 flt_d = sel_instr ? FLT_IPAGE : FLT_DPAGE;
    endcase
  end

  assign rsp_hit_d    = (flt_d == FLT_NONE);
  assign rsp_en       = req_valid;
  assign fa_en        = req_valid && !rsp_hit_d;
  assign fault_addr_d = req_addr;

  // response registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_hit_q    <= 1'b0;
      rsp_paddr_q  <= '0;
      rsp_rights_q <= '0;
      rsp_fault_q  <= '0;
      fault_addr_q <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      if (rsp_en) begin
        rsp_hit_q    <= rsp_hit_d;
        rsp_paddr_q  <= lk_phys;
        rsp_rights_q <= lk_rights;
        rsp_fault_q  <= flt_d;
      end
      if (fa_en) begin
        fault_addr_q <= fault_addr_d;
      end
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_paddr  = rsp_paddr_q;
  assign rsp_rights = rsp_rights_q;
  assign rsp_fault  = rsp_fault_q;
  assign fault_addr = fault_addr_q;

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid) else $error("missing response"); // R10
  AST_RSP_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid) else $error("spurious response"); // R10
  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit == (rsp_fault == 3'd0)) &&
                  (rsp_hit || (rsp_paddr == '0 && rsp_rights == '0))) else $error("hit/fault mix"); // R12
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_paddr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0]))
    else $error("offset altered"); // R7
  AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(req_super) && ($past(req_addr) < BYPASS_TOP) |->
      rsp_hit && rsp_paddr == $past(req_addr) && rsp_rights == 3'b011) else $error("bypass"); // R8
  AST_WRITE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit && ($past(req_kind) == 2'd1) |-> rsp_rights[RT_WR])
    else $error("write without right"); // R6
  AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> fault_addr == $past(req_addr)) else $error("fault addr"); // R9
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && !rsp_hit) |-> $stable(fault_addr)) else $error("fault addr moved"); // R9

endmodule

// File: tb/tlbx_unit_test.sv
module tlbx_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_super = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_instr = 1'b0;
  logic [5:0]  wr_index = '0;
  logic [31:0] wr_match = '0;
  logic [31:0] wr_xlate = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_rights;
  logic [2:0]  rsp_fault;
  logic [31:0] fault_addr;

  always #4 clk = ~clk;

  tlbx_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_super(req_super), .wr_en(wr_en), .wr_instr(wr_instr),
    .wr_index(wr_index), .wr_match(wr_match), .wr_xlate(wr_xlate),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_rights(rsp_rights), .rsp_fault(rsp_fault), .fault_addr(fault_addr)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  // behavioural reference state
  bit [31:0] m_match [2][64];
  bit [31:0] m_xl    [2][64];
  bit        m_vld   [2][64];
  bit        m_touched;
  int        last_side = -1;
  int        last_idx = -1;

  bit        e_rv, e_hit;
  bit [31:0] e_pa, e_fa;
  bit [2:0]  e_rt, e_ft;
  string     e_tag = "R1";

  task automatic model(input bit [31:0] a, input bit [1:0] k, input bit s,
                       output bit hit, output bit [31:0] pa, output bit [2:0] rt,
                       output bit [2:0] ft, output string tag);
    int side;
    int idx;
    bit [31:0] mw, tw;
    bit r, w, x, f;
    f = (k == 2'd2);
    side = f ? 1 : 0;
    idx = (a >> 13) & 63;
    hit = 0; pa = 0; rt = 0; ft = 0;
    if (s && a < 32'h2000) begin
      hit = 1; pa = a; rt = 3'b011; tag = "R8";
      return;
    end
    mw = m_match[side][idx];
    tw = m_xl[side][idx];
    if (!m_touched) begin
      ft = f ? 3'd1 : 3'd2; tag = "R1 R12";
      return;
    end
    if ((mw >> 13) != (a >> 13)) begin
      ft = f ? 3'd1 : 3'd2; tag = "R2 R3 R12";
      return;
    end
    if (!m_vld[side][idx]) begin
      ft = f ? 3'd1 : 3'd2; tag = "R4 R12";
      return;
    end
    r = s ? tw[0] : tw[3];
    w = s ? tw[1] : tw[4];
    x = s ? tw[2] : tw[5];
    if ((f && !x) || (k == 2'd1 && !w) || ((k == 2'd0 || k == 2'd3) && !r)) begin
      ft = f ? 3'd3 : 3'd4; tag = "R6 R12";
      return;
    end
    hit = 1;
    pa = {tw[31:13], a[12:0]};
    rt = f ? {x, 2'b00} : {1'b0, w, r};
    tag = "R5 R7";
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      e_rv = 0; e_hit = 0; e_pa = 0; e_rt = 0; e_ft = 0; e_fa = 0; e_tag = "R1";
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < 64; i++) m_vld[s][i] = 0;
      end
      m_touched = 0;
      last_side = -1;
    end else begin
      e_rv = req_valid;
      if (req_valid) begin
        model(req_addr, req_kind, req_super, e_hit, e_pa, e_rt, e_ft, e_tag);
        if (last_side == ((req_kind == 2'd2) ? 1 : 0) && last_idx == ((req_addr >> 13) & 63))
          e_tag = {e_tag, " R11"};
        if (e_ft != 0) e_fa = req_addr;
      end
      if (wr_en) begin
        m_match[wr_instr][wr_index] = wr_match;
        m_xl[wr_instr][wr_index]    = wr_xlate;
        m_vld[wr_instr][wr_index]   = wr_match[0];
        m_touched = 1;
        last_side = wr_instr;
        last_idx  = wr_index;
      end else begin
        last_side = -1;
      end
    end
  end

  function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    chk(rst_n ? "R10" : "R1", "rsp_valid", {31'b0, rsp_valid}, {31'b0, e_rv});
    if (e_rv) begin
      chk(e_tag, "rsp_hit",    {31'b0, rsp_hit},    {31'b0, e_hit});
      chk(e_tag, "rsp_paddr",  rsp_paddr,           e_pa);
      chk(e_tag, "rsp_rights", {29'b0, rsp_rights}, {29'b0, e_rt});
      chk(e_tag, "rsp_fault",  {29'b0, rsp_fault},  {29'b0, e_ft});
    end
    chk(rst_n ? "R9" : "R1", "fault_addr", fault_addr, e_fa);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  function automatic bit [31:0] mk_match(bit [31:0] va, bit v);
    return {va[31:13], 12'b0, v};
  endfunction

  function automatic bit [31:0] mk_xl(bit [31:0] frame, bit [5:0] perm);
    return {frame[31:13], 7'b0, perm};
  endfunction

  task automatic quiet();
    @(negedge clk); #1;
    req_valid = 0; wr_en = 0;
  endtask

  task automatic req(bit [31:0] a, bit [1:0] k, bit s);
    @(negedge clk); #1;
    wr_en = 0; req_valid = 1; req_addr = a; req_kind = k; req_super = s;
  endtask

  task automatic load(bit instr, bit [31:0] va, bit v, bit [31:0] frame, bit [5:0] perm);
    @(negedge clk); #1;
    req_valid = 0; wr_en = 1; wr_instr = instr; wr_index = va[18:13];
    wr_match = mk_match(va, v); wr_xlate = mk_xl(frame, perm);
  endtask

  task automatic load_req(bit instr, bit [31:0] va, bit [5:0] perm, bit [31:0] a, bit [1:0] k, bit s);
    @(negedge clk); #1;
    wr_en = 1; wr_instr = instr; wr_index = va[18:13];
    wr_match = mk_match(va, 1'b1); wr_xlate = mk_xl(32'h1234_6000, perm);
    req_valid = 1; req_addr = a; req_kind = k; req_super = s;
  endtask

  initial begin
    bit [31:0] lfsr;
    lfsr = 32'hACE1_2468;
    rst_n = 0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    // R1: empty tables miss on both sides
    req(32'h0000_4010, 2'd0, 1'b0);
    req(32'h0000_4010, 2'd2, 1'b0);
    // data entry: sup rd/wr, user read only
    load(1'b0, 32'h2468_A000, 1'b1, 32'h8000_0000, 6'b001011);
    req(32'h2468_A123, 2'd0, 1'b0);   // R5 R7 hit rights 001
    req(32'h2468_A124, 2'd1, 1'b0);   // R6 data page fault
    req(32'h2468_A128, 2'd1, 1'b1);   // R5 supervisor write hit
    req(32'h2468_A12C, 2'd3, 1'b0);   // kind 3 read
    req(32'h2468_A130, 2'd2, 1'b0);   // R11 instr table untouched: miss
    // R11: write and lookup in the same cycle
    load_req(1'b1, 32'h2468_A000, 6'b100000, 32'h2468_A040, 2'd2, 1'b0);
    req(32'h2468_A044, 2'd2, 1'b0);   // now hits, rights 100
    req(32'h2468_A048, 2'd2, 1'b1);   // R6 supervisor lacks execute
    // R3 same index, other tag
    req(32'h0000_A000, 2'd0, 1'b1);
    // R4 invalidate data entry
    load(1'b0, 32'h2468_A000, 1'b0, 32'h8000_0000, 6'b111111);
    req(32'h2468_A010, 2'd0, 1'b1);
    // R8 bypass window
    req(32'h0000_1FFC, 2'd0, 1'b1);
    req(32'h0000_0100, 2'd2, 1'b1);
    req(32'h0000_1FFC, 2'd0, 1'b0);
    req(32'h0000_2000, 2'd1, 1'b1);
    // R9 hold across idle cycles
    quiet(); quiet(); quiet();
    // mixed traffic
    for (int n = 0; n < 800; n++) begin
      bit [31:0] va;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      va = {(lfsr[3] ? 19'h7_A000 : 19'h0_0100) | {17'b0, lfsr[5:4]}, lfsr[16:4]};
      if (lfsr[9:8] == 2'b00) va = {19'b0, lfsr[20:8]};
      if (lfsr[2:0] == 3'd0) begin
        load(lfsr[6], va, lfsr[7] | lfsr[10], {lfsr[31:13], 13'b0}, lfsr[29:24]);
      end else if (lfsr[2:0] == 3'd1) begin
        quiet();
      end else if (lfsr[2:0] == 3'd2) begin
        load_req(lfsr[6], va, lfsr[29:24], va ^ {19'b0, lfsr[12:0]}, lfsr[12:11], lfsr[13]);
      end else begin
        req(va, lfsr[12:11], lfsr[13]);
      end
    end
    quiet(); quiet();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule